// File: doc/BRIEF.md
# Bus-Fault Diagnostic Pattern Engine

This block fills a byte-wide memory with a diagnostic pattern chosen so that a single stuck or open address or data line can be identified from what is read back. It walks every address in ascending order and writes a byte that it computes from the address itself, so no stored image is needed. The two extreme addresses hold the two all-equal bytes. The neighbours of those extremes that are one address line away carry a per-line code. Every other location carries one of six filler bytes. Each filler byte is at least three bits away from every other byte in the pattern.

A second run mode re-reads the whole array, rebuilds the same byte for each returned word, and counts the locations that differ. Fill and check are started separately, so the array can be written under benign conditions and read back later under stress. The memory port is a plain request/busy handshake with in-order read returns. The value generator is a two-stage pipeline, so one address is issued every cycle that the memory does not stall.

The controller is a four-state machine. `S_IDLE` waits for `start` and goes to `S_FILL` when `op_check` is 0, or to `S_CHECK` when it is 1. `S_FILL` goes to `S_DONE` when the last write is accepted. `S_CHECK` goes to `S_DONE` when the last returned word has been compared. `S_DONE` lasts one cycle and always goes back to `S_IDLE`.

Top module: `busfault_fill`

## Requirements
- R1: After reset `done`, `mem_req` and `mem_we` are 0 and `mismatch_cnt` is 0.
- R2: A `start` pulse with `op_check`=0 writes every address from 0 to 2^ADDR_W-1 exactly once, in ascending order, with `mem_we`=1. A write counts only on a cycle with `mem_req`=1 and `mem_busy`=0.
- R3: While `mem_req`=1 and `mem_busy`=1, the next cycle keeps `mem_req`=1 and leaves `mem_addr` and `mem_wdata` unchanged.
- R4: Address 0 receives 0xFF and the all-ones address receives 0x00.
- R5: An address with only bit k set, or with only bit k clear, receives line code k. The codes for k=0..21 are 07,0B,0D,0E,16,1A,1C,1F,25,29,2C,2F,34,38,3D,3E,43,49,4A,4F,52,58. ADDR_W ranges from 3 to 22.
- R6: Every other address receives a filler byte selected by (number of set address bits) mod 6: 0→33, 1→55, 2→66, 3→99, 4→AA, 5→CC.
- R7: A `start` pulse with `op_check`=1 clears `mismatch_cnt` and issues reads to every address in ascending order with `mem_we`=0. Each word returned on `mem_rvalid` is compared, in order, with the R4–R6 byte for its address, and each difference adds one to `mismatch_cnt`.
- R8: `done` is high for exactly one cycle after the last write is accepted (fill) or the last word is compared (check). A `start` pulse during a run has no effect.
- R9: With `mem_busy` held low, requests are accepted on consecutive cycles, with no idle cycle between the first and the last.
- R10: A fill run leaves `mismatch_cnt` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run; ignored unless idle |
| op_check | input | 1 | Sampled at start: 0 = fill, 1 = check |
| done | output | 1 | One-cycle pulse at the end of a run |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Request address |
| mem_wdata | output | 8 | Write byte |
| mem_busy | input | 1 | Memory refuses the current request |
| mem_rvalid | input | 1 | Read word returned, in request order |
| mem_rdata | input | 8 | Returned read byte |
| mismatch_cnt | output | CNT_W | Differences found in the last check run |

## Verification
The bench aims busy stalls at the request stream. A generator pipeline that slipped during a stall would skip or repeat an address, or change the byte partway through a handshake. It reads back the extremes, a one-set address and a one-clear address for the same line, and filler addresses of several weights. A wrong class priority or a wrong mod-6 index would put the wrong byte there. A check run is done over a clean array and again over an array with planted errors, to catch a counter that misses differences, counts stale data, or is not cleared. A restart pulse during a run and a stall-free fill expose a state machine that can be re-triggered, or a pipeline that inserts bubbles.

// File: rtl/bf_pattern_pkg.sv
package bf_pattern_pkg;

    localparam int BYTE_W   = 8;
    localparam int MAX_PINS = 22;
    localparam int IDX_W    = 5;

    typedef enum logic [1:0] {
        S_IDLE,
        S_FILL,
        S_CHECK,
        S_DONE
    } bf_state_t;

    // Per-line code: two bits apart from each other, three from 00/FF.
    function automatic logic [BYTE_W-1:0] pin_code(input logic [IDX_W-1:0] k);
        logic [BYTE_W-1:0] v;
        case (k)
            5'd0:  v = 8'h07;
            5'd1:  v = 8'h0B;
            5'd2:  v = 8'h0D;
            5'd3:  v = 8'h0E;
            5'd4:  v = 8'h16;
            5'd5:  v = 8'h1A;
            5'd6:  v = 8'h1C;
            5'd7:  v = 8'h1F;
            5'd8:  v = 8'h25;
            5'd9:  v = 8'h29;
            5'd10: v = 8'h2C;
            5'd11: v = 8'h2F;
            5'd12: v = 8'h34;
            5'd13: v = 8'h38;
            5'd14: v = 8'h3D;
            5'd15: v = 8'h3E;
            5'd16: v = 8'h43;
            5'd17: v = 8'h49;
            5'd18: v = 8'h4A;
            5'd19: v = 8'h4F;
            5'd20: v = 8'h52;
            5'd21: v = 8'h58;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

    function automatic logic [BYTE_W-1:0] filler_code(input logic [2:0] sel);
        logic [BYTE_W-1:0] v;
        case (sel)
            3'd0:    v = 8'h33;
            3'd1:    v = 8'h55;
            3'd2:    v = 8'h66;
            3'd3:    v = 8'h99;
            3'd4:    v = 8'hAA;
            default: v = 8'hCC;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/bf_pattern_gen.sv
module bf_pattern_gen
    import bf_pattern_pkg::*;
#(
    parameter int ADDR_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic [BYTE_W-1:0] out_data
);

    localparam int PC_W = $clog2(ADDR_W + 1);

    logic [PC_W-1:0]  pc_c;
    logic [IDX_W-1:0] idx_set_c, idx_clr_c;

    always_comb begin
        pc_c      = '0;
        idx_set_c = '0;
        idx_clr_c = '0;
        for (int i = 0; i < ADDR_W; i++) begin
            pc_c = pc_c + PC_W'(in_addr[i]);
            if (in_addr[i]) idx_set_c = IDX_W'(i);
            else            idx_clr_c = IDX_W'(i);
        end
    end

    // Stage 1: weight and class flags
    logic              s1_v, s1_zero, s1_ones, s1_hot, s1_cold;
    logic [ADDR_W-1:0] s1_addr;
    logic [PC_W-1:0]   s1_pc;
    logic [IDX_W-1:0]  s1_idx_set, s1_idx_clr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v <= 1'b0;
        end else if (!stall) begin
            s1_v       <= in_valid;
            s1_addr    <= in_addr;
            s1_pc      <= pc_c;
            s1_zero    <= (pc_c == '0);
            s1_ones    <= (pc_c == PC_W'(ADDR_W));
            s1_hot     <= (pc_c == PC_W'(1));
            s1_cold    <= (pc_c == PC_W'(ADDR_W - 1));
            s1_idx_set <= idx_set_c;
            s1_idx_clr <= idx_clr_c;
        end
    end

    // Stage 2: class priority and mod-6 selection
    logic [BYTE_W-1:0] val_c;

    always_comb begin
        if (s1_zero)      val_c = 8'hFF;
        else if (s1_ones) val_c = 8'h00;
        else if (s1_hot)  val_c = pin_code(s1_idx_set);
        else if (s1_cold) val_c = pin_code(s1_idx_clr);
        else              val_c = filler_code(3'(s1_pc % PC_W'(6)));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_addr  <= '0;
            out_data  <= '0;
        end else if (!stall) begin
            out_valid <= s1_v;
            out_addr  <= s1_addr;
            out_data  <= val_c;
        end
    end

    a_r4_zero_gets_ff: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_addr == '0 |-> out_data == 8'hFF);

    a_r4_ones_gets_00: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_addr == '1 |-> out_data == 8'h00);

endmodule

// File: rtl/busfault_fill.sv
module busfault_fill
    import bf_pattern_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_check,
    output logic              done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic              mem_busy,
    input  logic              mem_rvalid,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [CNT_W-1:0]  mismatch_cnt
);

    localparam int              GEN_LAT = 2;
    localparam logic [ADDR_W:0] DEPTH   = (ADDR_W + 1)'(1) << ADDR_W;
    localparam logic [ADDR_W:0] LAST    = DEPTH - 1'b1;

    bf_state_t state, state_nx;

    logic [ADDR_W:0] iss_cnt, acc_cnt, rtn_cnt, cmp_cnt;
    logic            run, feed, stall, accept, launch;
    logic            g1_v, g2_v;
    logic [ADDR_W-1:0] g1_addr, g2_addr;
    logic [BYTE_W-1:0] g1_data, g2_data;
    logic [BYTE_W-1:0] rd_pipe [GEN_LAT];

    assign run    = (state == S_FILL) || (state == S_CHECK);
    assign feed   = run && (iss_cnt < DEPTH);
    assign stall  = g1_v && mem_busy;
    assign accept = g1_v && !mem_busy;
    assign launch = (state == S_IDLE) && start;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (start) state_nx = op_check ? S_CHECK : S_FILL;
            S_FILL:  if (accept && acc_cnt == LAST) state_nx = S_DONE;
            S_CHECK: if (g2_v && cmp_cnt == LAST) state_nx = S_DONE;
            S_DONE:  state_nx = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        done      = (state == S_DONE);
        mem_req   = g1_v;
        mem_we    = (state == S_FILL);
        mem_addr  = g1_addr;
        mem_wdata = g1_data;
    end

    // Counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iss_cnt      <= '0;
            acc_cnt      <= '0;
            rtn_cnt      <= '0;
            cmp_cnt      <= '0;
            mismatch_cnt <= '0;
        end else if (launch) begin
            iss_cnt <= '0;
            acc_cnt <= '0;
            rtn_cnt <= '0;
            cmp_cnt <= '0;
            if (op_check) mismatch_cnt <= '0;
        end else begin
            if (feed && !stall)                    iss_cnt <= iss_cnt + 1'b1;
            if (accept)                            acc_cnt <= acc_cnt + 1'b1;
            if (mem_rvalid && state == S_CHECK)    rtn_cnt <= rtn_cnt + 1'b1;
            if (g2_v) begin
                cmp_cnt <= cmp_cnt + 1'b1;
                if (g2_data != rd_pipe[GEN_LAT-1]) mismatch_cnt <= mismatch_cnt + 1'b1;
            end
        end
    end

    // Returned data delayed to line up with the check-side generator
    always_ff @(posedge clk) begin
        rd_pipe[0] <= mem_rdata;
    end
    for (genvar g = 1; g < GEN_LAT; g++) begin : g_rd_dly
        always_ff @(posedge clk) rd_pipe[g] <= rd_pipe[g-1];
    end

    bf_pattern_gen #(.ADDR_W(ADDR_W)) i_issue_gen (
        .clk(clk), .rst_n(rst_n), .stall(stall),
        .in_valid(feed), .in_addr(iss_cnt[ADDR_W-1:0]),
        .out_valid(g1_v), .out_addr(g1_addr), .out_data(g1_data)
    );

    bf_pattern_gen #(.ADDR_W(ADDR_W)) i_check_gen (
        .clk(clk), .rst_n(rst_n), .stall(1'b0),
        .in_valid(mem_rvalid && state == S_CHECK), .in_addr(rtn_cnt[ADDR_W-1:0]),
        .out_valid(g2_v), .out_addr(g2_addr), .out_data(g2_data)
    );

    // Tracking for the ordering assertion
    logic              seen_acc;
    logic [ADDR_W-1:0] last_acc;
    always_ff @(posedge clk) begin
        if (!rst_n || launch) begin
            seen_acc <= 1'b0;
            last_acc <= '0;
        end else if (accept) begin
            seen_acc <= 1'b1;
            last_acc <= mem_addr;
        end
    end

    a_r2_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        accept && seen_acc |-> mem_addr == last_acc + 1'b1);

    a_r3_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_busy |=> mem_req && $stable(mem_addr) && $stable(mem_wdata));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        launch && op_check |=> mismatch_cnt == '0);

    a_r10_fill_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_FILL |=> $stable(mismatch_cnt));

endmodule

// File: tb/test_busfault_fill.sv
module test_busfault_fill;

    localparam int AW = 9;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          op_check = 1'b0;
    logic          done, mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic          mem_busy = 1'b0;
    logic          mem_rvalid = 1'b0;
    logic [7:0]    mem_rdata = 8'h00;
    logic [31:0]   mismatch_cnt;

    always #2.5 clk = ~clk;

    busfault_fill #(.ADDR_W(AW), .CNT_W(32)) i_busfault_fill (
        .clk(clk), .rst_n(rst_n), .start(start), .op_check(op_check),
        .done(done), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_busy(mem_busy),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .mismatch_cnt(mismatch_cnt)
    );

    int errors = 0;
    int checks = 0;

    task automatic check(input string req, input logic ok, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_val(input int a);
        logic [7:0] codes [22] = '{8'h07,8'h0B,8'h0D,8'h0E,8'h16,8'h1A,8'h1C,8'h1F,
                                   8'h25,8'h29,8'h2C,8'h2F,8'h34,8'h38,8'h3D,8'h3E,
                                   8'h43,8'h49,8'h4A,8'h4F,8'h52,8'h58};
        logic [7:0] fill [6] = '{8'h33,8'h55,8'h66,8'h99,8'hAA,8'hCC};
        int ones = 0;
        int set_k = 0;
        int clr_k = 0;
        for (int i = 0; i < AW; i++) begin
            if (a[i]) begin ones++; set_k = i; end
            else clr_k = i;
        end
        if (ones == 0)  return 8'hFF;
        if (ones == AW) return 8'h00;
        if (ones == 1)  return codes[set_k];
        if (ones == AW - 1) return codes[clr_k];
        return fill[ones % 6];
    endfunction

    // Scoreboard state
    int         q_addr [$];
    logic [7:0] q_data [$];
    logic       q_we   [$];
    logic [7:0] mem_model [N];
    logic       busy_rand = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    int         done_cnt = 0;
    logic       pend_rd = 1'b0;
    int         pend_addr = 0;
    logic       prev_req = 1'b0, prev_busy = 1'b0;
    logic [AW-1:0] prev_addr = '0;
    logic [7:0] prev_wdata = '0;
    logic       measuring = 1'b0, seen_first = 1'b0;
    int         gaps = 0;

    // Memory model and monitor
    always @(negedge clk) begin
        logic nb;
        mem_rvalid <= pend_rd;
        if (pend_rd) mem_rdata <= mem_model[pend_addr];
        pend_rd = 1'b0;
        if (done) done_cnt++;
        if (rst_n) begin
            if (prev_req && prev_busy)
                check("R3", mem_req && mem_addr == prev_addr && mem_wdata == prev_wdata,
                      {mem_req, mem_addr, mem_wdata}, {1'b1, prev_addr, prev_wdata});
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            nb = busy_rand && lfsr[0] && lfsr[3];
            mem_busy = nb;
            if (measuring) begin
                if (mem_req) seen_first = 1'b1;
                else if (seen_first && q_addr.size() != 0) gaps++;
            end
            if (mem_req && !nb) begin
                if (q_addr.size() == 0) begin
                    check("R8", 1'b0, mem_addr, 0);
                end else begin
                    int ea;
                    logic [7:0] ed;
                    logic ew;
                    ea = q_addr.pop_front();
                    ed = q_data.pop_front();
                    ew = q_we.pop_front();
                    check("R2", int'(mem_addr) == ea && mem_we == ew,
                          {mem_we, mem_addr}, {ew, ea[AW-1:0]});
                    if (ew) begin
                        check("R6", mem_wdata == ed, mem_wdata, ed);
                        mem_model[mem_addr] = mem_wdata;
                    end else begin
                        pend_rd = 1'b1;
                        pend_addr = int'(mem_addr);
                    end
                end
            end
            prev_req   = mem_req;
            prev_busy  = nb;
            prev_addr  = mem_addr;
            prev_wdata = mem_wdata;
        end
    end

    task automatic run_pass(input logic chk, input logic restart_mid);
        for (int a = 0; a < N; a++) begin
            q_addr.push_back(a);
            q_data.push_back(exp_val(a));
            q_we.push_back(!chk);
        end
        done_cnt = 0;
        @(negedge clk);
        start = 1'b1; op_check = chk;
        @(negedge clk);
        start = 1'b0;
        if (restart_mid) begin
            repeat (40) @(negedge clk);
            start = 1'b1; op_check = !chk;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        repeat (3) @(negedge clk);
        check("R8", done_cnt == 1 && q_addr.size() == 0, done_cnt, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int a = 0; a < N; a++) mem_model[a] = 8'h5A;
        repeat (4) @(negedge clk);
        check("R1", !done && !mem_req && !mem_we && mismatch_cnt == 0,
              {done, mem_req, mem_we, mismatch_cnt}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", !done && !mem_req && mismatch_cnt == 0, {done, mem_req}, 0);

        // Fill under random stalls, with an ignored restart pulse
        busy_rand = 1'b1;
        run_pass(1'b0, 1'b1);
        check("R4", mem_model[0] == 8'hFF, mem_model[0], 8'hFF);
        check("R4", mem_model[N-1] == 8'h00, mem_model[N-1], 8'h00);
        check("R5", mem_model[1] == 8'h07, mem_model[1], 8'h07);
        check("R5", mem_model[N-2] == 8'h07, mem_model[N-2], 8'h07);
        check("R5", mem_model[256] == 8'h25, mem_model[256], 8'h25);
        check("R5", mem_model[N-1-256] == 8'h25, mem_model[N-1-256], 8'h25);
        check("R6", mem_model[3] == 8'h66, mem_model[3], 8'h66);
        check("R6", mem_model[7] == 8'h99, mem_model[7], 8'h99);
        check("R6", mem_model[63] == 8'h33, mem_model[63], 8'h33);
        check("R6", mem_model[127] == 8'h55, mem_model[127], 8'h55);
        check("R10", mismatch_cnt == 0, mismatch_cnt, 0);

        // Clean check pass
        run_pass(1'b1, 1'b0);
        check("R7", mismatch_cnt == 0, mismatch_cnt, 0);

        // Planted errors
        mem_model[0]   = 8'hFE;
        mem_model[1]   = 8'h0F;
        mem_model[100] = ~mem_model[100];
        run_pass(1'b1, 1'b1);
        check("R7", mismatch_cnt == 3, mismatch_cnt, 3);

        // Stall-free fill restores memory, keeps count, no bubbles
        busy_rand = 1'b0;
        measuring = 1'b1;
        run_pass(1'b0, 1'b0);
        measuring = 1'b0;
        check("R9", gaps == 0 && seen_first, gaps, 0);
        check("R10", mismatch_cnt == 3, mismatch_cnt, 3);
        check("R4", mem_model[0] == 8'hFF, mem_model[0], 8'hFF);

        // Count cleared on next check start
        busy_rand = 1'b1;
        run_pass(1'b1, 1'b0);
        check("R7", mismatch_cnt == 0, mismatch_cnt, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule